// File: doc/BRIEF.md
# Byte-packing four-byte data buffer

This block sits between a 16-bit host data register and a byte-serial shift engine. It holds one 32-bit store of four byte lanes. The host writes 16-bit words, and each word is pushed in as two bytes. The engine pulls those bytes out one at a time, highest occupied lane first. In the other direction, the engine pushes received bytes in from the bottom lane upward, and the host reads them back two at a time.

A byte-order input chooses which byte of a host word maps to which lane. There are two byte counts, one for transmit and one for receive. The block drives level flags to the status unit: transmit-ready, receive-ready, transmit underflow, receive overrun, and a single-byte flag that marks a read which found only one byte.

Each cycle takes one of four strobes: host write, host read, engine push or engine pull. If more than one is raised, the host write wins, then the host read, then the push, then the pull.

Top module: `byte_pack_buf`

## Requirements
- R1: After reset, both counts are 0, all five flags are 0, and the read word and the outgoing byte are both 0.
- R2: A host write with `hi_first`=1 puts the word's bits [15:8] in lane 1 and bits [7:0] in lane 0. With `hi_first`=0 the two bytes are swapped. Older lanes move up by two, and the transmit count rises by 2. Lane n occupies bits [8n+7:8n] of the store.
- R3: A host write is ignored when the transmit count is above 2. Otherwise it clears the underflow flag, and it clears transmit-ready when more than 2 bytes are pending afterwards.
- R4: With a transmit count c > 0, `eng_tx_byte` shows lane c-1. A pull lowers the count by 1, zeroes that lane and sets transmit-ready.
- R5: With a transmit count of 0, `eng_tx_byte` is 0. A pull leaves the count at 0 and sets both underflow and transmit-ready.
- R6: With a receive count r < 4, a push stores the byte in lane r and raises the count by 1. Every push sets receive-ready and clears the single-byte flag.
- R7: A push while the receive count is 4 drops the byte and sets the overrun flag. Receive-ready is still set, and the count and lanes stay unchanged.
- R8: `host_rdata` is {lane 0, lane 1} when `hi_first`=1 and {lane 1, lane 0} when it is 0. A read with a receive count of 2 or more shifts the store down by 16 bits, with zero fill, and lowers the count by 2. Receive-ready clears when the count reaches 0.
- R9: A read with a receive count of exactly 1 sets the single-byte flag, empties the receive side (count 0, store shifted down by 16) and clears receive-ready.
- R10: Every host read clears the overrun flag.
- R11: A read with a receive count of 0 leaves the store, both counts and receive-ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_first | input | 1 | Byte-order select for host words |
| host_wr | input | 1 | Host word write strobe |
| host_wdata | input | 16 | Host write word |
| host_rd | input | 1 | Host word read strobe |
| host_rdata | output | 16 | Word presented to the host |
| eng_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_pull | input | 1 | Engine takes a transmit byte |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| tx_count | output | 3 | Pending transmit bytes (0 to 4) |
| rx_count | output | 3 | Held receive bytes (0 to 4) |
| tx_ready | output | 1 | Transmit-ready flag |
| rx_ready | output | 1 | Receive-ready flag |
| tx_underflow | output | 1 | Transmit underflow flag |
| rx_overrun | output | 1 | Receive overrun flag |
| odd_byte | output | 1 | Single-byte-data flag |

## Verification
The assertions take for granted that at most one of the four strobes is high in any cycle. Their consequents state what a lone strobe does, so they do not hold if strobes overlap and the priority order applies. One property checks that the strobes are exclusive.

The directed sequences and the random phase both raise exactly one strobe, or none, per cycle. Because of this, the priority order is never exercised. Within that limit, the random phase still mixes transmit and receive traffic over the shared lanes.

// File: rtl/byte_pack_buf.sv
module byte_pack_buf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hi_first,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  input  logic        host_rd,
  output logic [15:0] host_rdata,
  input  logic        eng_push,
  input  logic [7:0]  eng_rx_byte,
  input  logic        eng_pull,
  output logic [7:0]  eng_tx_byte,
  output logic [2:0]  tx_count,
  output logic [2:0]  rx_count,
  output logic        tx_ready,
  output logic        rx_ready,
  output logic        tx_underflow,
  output logic        rx_overrun,
  output logic        odd_byte
);
  localparam int LANES = 4;
  localparam logic [2:0] FULL = 3'(LANES);

  logic [31:0] lanes_q;
  logic [1:0]  top_lane;
  logic [15:0] word_in;

  assign top_lane    = tx_count[1:0] - 2'd1;
  assign word_in     = hi_first ? host_wdata : {host_wdata[7:0], host_wdata[15:8]};
  assign host_rdata  = hi_first ? {lanes_q[7:0], lanes_q[15:8]} : lanes_q[15:0];
  assign eng_tx_byte = (tx_count == 3'd0) ? 8'h00 : lanes_q[{top_lane, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lanes_q      <= '0;
      tx_count     <= '0;
      rx_count     <= '0;
      tx_ready     <= 1'b0;
      rx_ready     <= 1'b0;
      tx_underflow <= 1'b0;
      rx_overrun   <= 1'b0;
      odd_byte     <= 1'b0;
    end else if (host_wr) begin
      if (tx_count <= 3'd2) begin
        lanes_q      <= {lanes_q[15:0], word_in};
        tx_count     <= tx_count + 3'd2;
        tx_underflow <= 1'b0;
        if (tx_count != 3'd0) tx_ready <= 1'b0;
      end
    end else if (host_rd) begin
      rx_overrun <= 1'b0;
      if (rx_count != 3'd0) begin
        lanes_q  <= lanes_q >> 16;
        rx_count <= (rx_count >= 3'd2) ? rx_count - 3'd2 : 3'd0;
        if (rx_count == 3'd1) odd_byte <= 1'b1;
        if (rx_count <= 3'd2) rx_ready <= 1'b0;
      end
    end else if (eng_push) begin
      rx_ready <= 1'b1;
      odd_byte <= 1'b0;
      if (rx_count == FULL) rx_overrun <= 1'b1;
      else begin
        lanes_q[{rx_count[1:0], 3'b000} +: 8] <= eng_rx_byte;
        rx_count <= rx_count + 3'd1;
      end
    end else if (eng_pull) begin
      tx_ready <= 1'b1;
      if (tx_count == 3'd0) tx_underflow <= 1'b1;
      else begin
        lanes_q[{top_lane, 3'b000} +: 8] <= 8'h00;
        tx_count <= tx_count - 3'd1;
      end
    end
  end
endmodule

// File: rtl/byte_pack_buf_chk.sv
module byte_pack_buf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic        eng_push,
  input logic        eng_pull,
  input logic [15:0] host_rdata,
  input logic [7:0]  eng_tx_byte,
  input logic [2:0]  tx_count,
  input logic [2:0]  rx_count,
  input logic        tx_ready,
  input logic        rx_ready,
  input logic        tx_underflow,
  input logic        rx_overrun,
  input logic        odd_byte
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_wr, host_rd, eng_push, eng_pull}));  // input contract
  AST_COUNTS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= 3'd4 && rx_count <= 3'd4);  // R6
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && tx_count > 3'd2 |=> $stable(tx_count));  // R3
  AST_EMPTY_PULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count == 3'd0 |-> eng_tx_byte == 8'h00);  // R5
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    eng_pull && !host_wr && !host_rd && !eng_push && tx_count == 3'd0
    |=> tx_underflow && tx_ready && tx_count == 3'd0);  // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    eng_push && !host_wr && !host_rd && rx_count == 3'd4
    |=> rx_overrun && rx_ready && rx_count == 3'd4);  // R7
  AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr |=> !rx_overrun);  // R10
  AST_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && rx_count == 3'd1 |=> odd_byte && rx_count == 3'd0 && !rx_ready);  // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && rx_count == 3'd0 |=> $stable(rx_count) && $stable(tx_count));  // R11
endmodule

bind byte_pack_buf byte_pack_buf_chk chk_i (.*);

// File: tb/byte_pack_buf_tb_top.sv
`timescale 1ns/1ps
module byte_pack_buf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, hi_first = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, eng_push = 1'b0, eng_pull = 1'b0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic [7:0]  eng_rx_byte = '0, eng_tx_byte;
  logic [2:0]  tx_count, rx_count;
  logic tx_ready, rx_ready, tx_underflow, rx_overrun, odd_byte;

  always #2.5 clk = ~clk;

  byte_pack_buf dut_i (.*);

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  int ml[4];
  int mtx, mrx;
  bit txr, rxr, udf, ovr, sbd;

  task automatic cmp(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("tx_count", tx_count, mtx);
    cmp("rx_count", rx_count, mrx);
    cmp("tx_ready", tx_ready, txr);
    cmp("rx_ready", rx_ready, rxr);
    cmp("tx_underflow", tx_underflow, udf);
    cmp("rx_overrun", rx_overrun, ovr);
    cmp("odd_byte", odd_byte, sbd);
    cmp("eng_tx_byte", eng_tx_byte, (mtx == 0) ? 0 : ml[mtx-1]);
    cmp("host_rdata", host_rdata, hi_first ? (ml[0] * 256 + ml[1]) : (ml[1] * 256 + ml[0]));
  endtask

  task automatic model_update();
    if (host_wr) begin
      if (mtx <= 2) begin
        ml[3] = ml[1]; ml[2] = ml[0];
        if (hi_first) begin ml[1] = host_wdata[15:8]; ml[0] = host_wdata[7:0]; end
        else          begin ml[1] = host_wdata[7:0];  ml[0] = host_wdata[15:8]; end
        mtx += 2; udf = 0;
        if (mtx > 2) txr = 0;
      end
    end else if (host_rd) begin
      ovr = 0;
      if (mrx > 0) begin
        if (mrx == 1) sbd = 1;
        ml[0] = ml[2]; ml[1] = ml[3]; ml[2] = 0; ml[3] = 0;
        mrx = (mrx >= 2) ? mrx - 2 : 0;
        if (mrx == 0) rxr = 0;
      end
    end else if (eng_push) begin
      rxr = 1; sbd = 0;
      if (mrx == 4) ovr = 1;
      else begin ml[mrx] = eng_rx_byte; mrx++; end
    end else if (eng_pull) begin
      txr = 1;
      if (mtx == 0) udf = 1;
      else begin mtx--; ml[mtx] = 0; end
    end
  endtask

  // op: 0 write, 1 read, 2 push, 3 pull, 4 idle
  task automatic step(int op, int data, bit order);
    hi_first = order;
    host_wr = (op == 0); host_rd = (op == 1); eng_push = (op == 2); eng_pull = (op == 3);
    host_wdata = 16'(data); eng_rx_byte = 8'(data);
    #1 check_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    foreach (ml[i]) ml[i] = 0;
    mtx = 0; mrx = 0; {txr, rxr, udf, ovr, sbd} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; step(4, 0, 0);
    cur_req = "R2"; step(0, 'hA1B2, 1);
    cur_req = "R4"; step(3, 0, 1); step(3, 0, 1);
    cur_req = "R5"; step(3, 0, 1); step(3, 0, 0);
    cur_req = "R2"; step(0, 'h1234, 0);
    cur_req = "R4"; step(3, 0, 0); step(3, 0, 0);
    cur_req = "R3"; step(0, 'h5566, 1); step(0, 'h7788, 0); step(0, 'h99AA, 1);
    cur_req = "R4"; repeat (4) step(3, 0, 1);
    cur_req = "R6"; step(2, 'h11, 1); step(2, 'h22, 1);
    cur_req = "R8"; step(1, 0, 1); step(4, 0, 1);
    cur_req = "R7"; for (int b = 1; b <= 5; b++) step(2, b, 0);
    cur_req = "R10"; step(1, 0, 0);
    cur_req = "R8"; step(1, 0, 1);
    cur_req = "R9"; step(2, 'h33, 0); step(2, 'h44, 0); step(2, 'h55, 1);
    step(1, 0, 1); step(1, 0, 0); step(4, 0, 0);
    cur_req = "R6"; step(2, 'h66, 0);
    cur_req = "R11"; step(1, 0, 1); step(1, 0, 1); step(1, 0, 0);
    cur_req = "R10"; repeat (5) step(2, 'h77, 0); step(1, 0, 0);
    cur_req = "mixed";
    for (int i = 0; i < 600; i++) step(int'($urandom_range(0, 4)), int'($urandom), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule